// File: doc/BRIEF.md
# Triple-Port Auxiliary RAM

This block is a small word-wide RAM that sits beside one processing core and gives three clients their own access paths. The core reads and writes through a dedicated port. The shared system bus reads and writes through a second, independent port. A display path streams data out through a third port, which can only read. All three ports can be used in the same clock cycle. A typical pattern is to fill a frame or line buffer from the bus while the display port reads it out, with the core working in another region at the same time.

Every read is synchronous and has one cycle of latency. A read that targets a word being written in the same cycle returns the contents that word held before the write. The core and the bus may both write the same word in one cycle. In that case the core's data is kept, the bus's data is dropped, and a one-cycle collision flag reports the event.

Top module: `auxRamTriple`

## Requirements
- R1: While reset is active and after it is released, the core, bus and video read-data outputs are all zero and the collision flag is low until a read or a collision occurs.
- R2: A core write (coreEn=1, coreWe=1) stores coreWdata at coreAddr. A core read (coreEn=1) presents the addressed word on coreRdata after exactly one clock edge.
- R3: A bus write (busEn=1, busWe=1) stores busWdata at busAddr. A bus read (busEn=1) presents the addressed word on busRdata one edge later. Words written by one port are visible to the other ports.
- R4: A video read (vidEn=1) presents the word at vidAddr on vidRdata one edge later. The video port never changes RAM contents.
- R5: A read on any port that addresses a word being written in the same cycle returns the word's previous contents.
- R6: In one cycle, a core write, a bus write and a video read to three distinct addresses all take effect.
- R7: When the core and the bus write the same address in the same cycle, the core's data is stored, the bus's data is discarded, and collision is high for the single cycle after that edge.
- R8: The collision flag stays low when the two write addresses differ, and when only one of the two ports writes.
- R9: A port whose enable is low leaves its read-data output unchanged and does not write, even when its write-enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset of output registers and flag |
| coreEn | input | 1 | Core port access enable |
| coreWe | input | 1 | Core port write select (1 = write) |
| coreAddr | input | ADDR_W | Core port word address |
| coreWdata | input | DATA_W | Core port write data |
| coreRdata | output | DATA_W | Core port read data, one cycle after the access |
| busEn | input | 1 | Bus port access enable |
| busWe | input | 1 | Bus port write select (1 = write) |
| busAddr | input | ADDR_W | Bus port word address |
| busWdata | input | DATA_W | Bus port write data |
| busRdata | output | DATA_W | Bus port read data, one cycle after the access |
| vidEn | input | 1 | Video port read enable |
| vidAddr | input | ADDR_W | Video port word address |
| vidRdata | output | DATA_W | Video port read data, one cycle after the access |
| collision | output | 1 | High for one cycle after a same-address core/bus write |

## Verification
The ports are driven in several patterns: a single port active, two ports crossing over (each reading what the other wrote), all three ports busy on distinct addresses, and reads aimed at a word being written in the same cycle. The crossover pattern separates a shared array from per-port copies. The same-cycle read separates read-before-write from write-through behaviour. Same-address dual writes, followed by readback, show whether the core really has priority and whether the flag lasts exactly one cycle. Different-address dual writes and disabled ports with the write select raised show that nothing spurious is flagged or stored.

// File: rtl/auxRamPkg.sv
package auxRamPkg;
  // Per-cycle strobes from control to the storage datapath
  typedef struct packed {
    logic coreWr;
    logic busWr;
    logic coreRd;
    logic busRd;
    logic vidRd;
  } auxStrobes_t;
endpackage

// File: rtl/auxRamCtrl.sv
module auxRamCtrl
  import auxRamPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coreEn,
  input  logic              coreWe,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic              busEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              vidEn,
  output auxStrobes_t       strobes,
  output logic              collision
);
  logic coreWants;
  logic busWants;
  logic sameWord;

  always_comb begin
    coreWants       = coreEn & coreWe;
    busWants        = busEn & busWe;
    sameWord        = coreWants & busWants & (coreAddr == busAddr);
    strobes.coreWr  = coreWants;
    strobes.busWr   = busWants & ~sameWord;   // core has priority
    strobes.coreRd  = coreEn;
    strobes.busRd   = busEn;
    strobes.vidRd   = vidEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) collision <= 1'b0;
    else       collision <= sameWord;
  end
endmodule

// File: rtl/auxRamStore.sv
module auxRamStore
  import auxRamPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  auxStrobes_t       strobes,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic [DATA_W-1:0] coreWdata,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [ADDR_W-1:0] vidAddr,
  output logic [DATA_W-1:0] coreRdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] vidRdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Writes: control guarantees both strobes never hit one word together
  always_ff @(posedge clk) begin
    if (strobes.coreWr) mem[coreAddr] <= coreWdata;
    if (strobes.busWr)  mem[busAddr]  <= busWdata;
  end

  // Registered reads sample the array before this edge's writes land
  always_ff @(posedge clk) begin
    if (!rstN) begin
      coreRdata <= '0;
      busRdata  <= '0;
      vidRdata  <= '0;
    end else begin
      if (strobes.coreRd) coreRdata <= mem[coreAddr];
      if (strobes.busRd)  busRdata  <= mem[busAddr];
      if (strobes.vidRd)  vidRdata  <= mem[vidAddr];
    end
  end
endmodule

// File: rtl/auxRamTriple.sv
module auxRamTriple
  import auxRamPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coreEn,
  input  logic              coreWe,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic [DATA_W-1:0] coreWdata,
  output logic [DATA_W-1:0] coreRdata,
  input  logic              busEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              vidEn,
  input  logic [ADDR_W-1:0] vidAddr,
  output logic [DATA_W-1:0] vidRdata,
  output logic              collision
);
  auxStrobes_t strobes;

  auxRamCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .coreEn(coreEn), .coreWe(coreWe), .coreAddr(coreAddr),
    .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .vidEn(vidEn),
    .strobes(strobes), .collision(collision)
  );

  auxRamStore #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .coreAddr(coreAddr), .coreWdata(coreWdata),
    .busAddr(busAddr), .busWdata(busWdata),
    .vidAddr(vidAddr),
    .coreRdata(coreRdata), .busRdata(busRdata), .vidRdata(vidRdata)
  );
endmodule

// File: rtl/auxRamTriple_chk.sv
module auxRamTriple_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              coreEn,
  input logic              coreWe,
  input logic [ADDR_W-1:0] coreAddr,
  input logic [DATA_W-1:0] coreRdata,
  input logic              busEn,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdata,
  input logic              vidEn,
  input logic [DATA_W-1:0] vidRdata,
  input logic              collision
);
  // R7: same-word dual write raises the flag on the next cycle
  a_r7_collision_flag: assert property (@(posedge clk) disable iff (!rstN)
    (coreEn && coreWe && busEn && busWe && coreAddr == busAddr) |=> collision);

  // R8: no dual same-word write means no flag
  a_r8_no_false_flag: assert property (@(posedge clk) disable iff (!rstN)
    !(coreEn && coreWe && busEn && busWe && coreAddr == busAddr) |=> !collision);

  // R9: disabled ports hold their read data
  a_r9_core_hold: assert property (@(posedge clk) disable iff (!rstN)
    !coreEn |=> $stable(coreRdata));
  a_r9_bus_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busEn |=> $stable(busRdata));
  a_r9_vid_hold: assert property (@(posedge clk) disable iff (!rstN)
    !vidEn |=> $stable(vidRdata));

  // R1: reset clears outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (coreRdata == '0 && busRdata == '0 && vidRdata == '0 && !collision));
endmodule

bind auxRamTriple auxRamTriple_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .coreEn(coreEn), .coreWe(coreWe), .coreAddr(coreAddr), .coreRdata(coreRdata),
  .busEn(busEn), .busWe(busWe), .busAddr(busAddr), .busRdata(busRdata),
  .vidEn(vidEn), .vidRdata(vidRdata), .collision(collision)
);

// File: tb/auxRamTriple_bench.sv
module auxRamTriple_bench;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic          coreEn, coreWe, busEn, busWe, vidEn;
  logic [AW-1:0] coreAddr, busAddr, vidAddr;
  logic [DW-1:0] coreWdata, busWdata;
  logic [DW-1:0] coreRdata, busRdata, vidRdata;
  logic          collision;

  int errors = 0;
  int checks = 0;
  bit doneFlag = 0;

  always #4 clk = ~clk;   // 125 MHz

  auxRamTriple #(.ADDR_W(AW), .DATA_W(DW)) u_auxRamTriple (
    .clk(clk), .rstN(rstN),
    .coreEn(coreEn), .coreWe(coreWe), .coreAddr(coreAddr),
    .coreWdata(coreWdata), .coreRdata(coreRdata),
    .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .vidEn(vidEn), .vidAddr(vidAddr), .vidRdata(vidRdata),
    .collision(collision)
  );

  typedef struct packed {
    logic          cE, cW;
    logic [AW-1:0] cA;
    logic [DW-1:0] cD;
    logic          bE, bW;
    logic [AW-1:0] bA;
    logic [DW-1:0] bD;
    logic          vE;
    logic [AW-1:0] vA;
    logic [DW-1:0] eC, eB, eV;
    logic          eColl;
    logic [2:0]    mask;   // {core, bus, vid} data checks
    logic [7:0]    req;    // requirement number for messages
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    // core writes 0x10, bus writes 0x20
    '{1'b1,1'b1,8'h10,32'h1111_0000, 1'b1,1'b1,8'h20,32'h2222_0000, 1'b0,8'h00, 32'h0,32'h0,32'h0, 1'b0,3'b000, 8'd2},
    // cross reads: R2/R3/R4
    '{1'b1,1'b0,8'h20,32'h0, 1'b1,1'b0,8'h10,32'h0, 1'b1,8'h10, 32'h2222_0000,32'h1111_0000,32'h1111_0000, 1'b0,3'b111, 8'd3},
    // R5: core writes 0x10 while all ports read 0x10 -> old data
    '{1'b1,1'b1,8'h10,32'hAAAA_5555, 1'b1,1'b0,8'h10,32'h0, 1'b1,8'h10, 32'h1111_0000,32'h1111_0000,32'h1111_0000, 1'b0,3'b111, 8'd5},
    // new data visible afterwards (R2)
    '{1'b1,1'b0,8'h10,32'h0, 1'b1,1'b0,8'h10,32'h0, 1'b1,8'h10, 32'hAAAA_5555,32'hAAAA_5555,32'hAAAA_5555, 1'b0,3'b111, 8'd2},
    // R6: two writes plus a video read, distinct addresses
    '{1'b1,1'b1,8'h30,32'h0000_0033, 1'b1,1'b1,8'h40,32'h0000_0044, 1'b1,8'h20, 32'h0,32'h0,32'h2222_0000, 1'b0,3'b001, 8'd6},
    '{1'b1,1'b0,8'h40,32'h0, 1'b1,1'b0,8'h30,32'h0, 1'b1,8'h30, 32'h0000_0044,32'h0000_0033,32'h0000_0033, 1'b0,3'b111, 8'd6},
    // R7: same-word collision, video idle holds
    '{1'b1,1'b1,8'h50,32'h0000_C0C0, 1'b1,1'b1,8'h50,32'h0000_B0B0, 1'b0,8'h00, 32'h0,32'h0,32'h0000_0033, 1'b1,3'b001, 8'd7},
    // R7: core data kept, flag gone after one cycle
    '{1'b1,1'b0,8'h50,32'h0, 1'b1,1'b0,8'h50,32'h0, 1'b1,8'h50, 32'h0000_C0C0,32'h0000_C0C0,32'h0000_C0C0, 1'b0,3'b111, 8'd7},
    // R8: only the core writes, bus reads elsewhere
    '{1'b1,1'b1,8'h30,32'h0000_3030, 1'b1,1'b0,8'h50,32'h0, 1'b0,8'h00, 32'h0000_0033,32'h0000_C0C0,32'h0000_C0C0, 1'b0,3'b111, 8'd8},
    // R8: two writes to different words
    '{1'b1,1'b1,8'h50,32'h0000_5050, 1'b1,1'b1,8'h10,32'h0000_0077, 1'b1,8'h50, 32'h0000_C0C0,32'hAAAA_5555,32'h0000_C0C0, 1'b0,3'b111, 8'd8},
    // R9: all disabled, write selects high: outputs hold
    '{1'b0,1'b1,8'h50,32'hDEAD_BEEF, 1'b0,1'b1,8'h10,32'hDEAD_BEEF, 1'b0,8'h50, 32'h0000_C0C0,32'hAAAA_5555,32'h0000_C0C0, 1'b0,3'b111, 8'd9},
    // R9: nothing was written by disabled ports
    '{1'b1,1'b0,8'h50,32'h0, 1'b1,1'b0,8'h10,32'h0, 1'b1,8'h30, 32'h0000_5050,32'h0000_0077,32'h0000_3030, 1'b0,3'b111, 8'd9}
  };

  task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic idle();
    coreEn = 0; coreWe = 0; coreAddr = '0; coreWdata = '0;
    busEn = 0; busWe = 0; busAddr = '0; busWdata = '0;
    vidEn = 0; vidAddr = '0;
  endtask

  task automatic apply(input vec_t v);
    coreEn = v.cE; coreWe = v.cW; coreAddr = v.cA; coreWdata = v.cD;
    busEn = v.bE; busWe = v.bW; busAddr = v.bA; busWdata = v.bD;
    vidEn = v.vE; vidAddr = v.vA;
    @(posedge clk); #1;
  endtask

  initial begin
    #1_000_000;
    if (!doneFlag) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    rstN = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 coreRdata", coreRdata, '0);
    chk("R1 busRdata", busRdata, '0);
    chk("R1 vidRdata", vidRdata, '0);
    chk("R1 collision", {31'b0, collision}, 32'd0);
    rstN = 1;
    @(posedge clk); #1;
    chk("R1 idle after release", {31'b0, collision} | coreRdata | busRdata | vidRdata, '0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      if (VEC[i].mask[2]) chk($sformatf("R%0d core vec%0d", VEC[i].req, i), coreRdata, VEC[i].eC);
      if (VEC[i].mask[1]) chk($sformatf("R%0d bus vec%0d", VEC[i].req, i), busRdata, VEC[i].eB);
      if (VEC[i].mask[0]) chk($sformatf("R%0d vid vec%0d", VEC[i].req, i), vidRdata, VEC[i].eV);
      chk($sformatf("R%0d collision vec%0d", VEC[i].req, i), {31'b0, collision}, {31'b0, VEC[i].eColl});
    end

    // R7: back-to-back collisions keep the flag high each cycle
    apply('{1'b1,1'b1,8'h70,32'h1,1'b1,1'b1,8'h70,32'h2,1'b0,8'h0,32'h0,32'h0,32'h0,1'b0,3'b0,8'd7});
    chk("R7 first collision", {31'b0, collision}, 32'd1);
    apply('{1'b1,1'b1,8'h71,32'h3,1'b1,1'b1,8'h71,32'h4,1'b0,8'h0,32'h0,32'h0,32'h0,1'b0,3'b0,8'd7});
    chk("R7 second collision", {31'b0, collision}, 32'd1);
    idle();
    @(posedge clk); #1;
    chk("R7 flag drops", {31'b0, collision}, 32'd0);
    // R7/R4: core data kept at both words, read via video
    vidEn = 1; vidAddr = 8'h70;
    @(posedge clk); #1;
    chk("R7 word 0x70", vidRdata, 32'h1);
    vidAddr = 8'h71;
    @(posedge clk); #1;
    chk("R7 word 0x71", vidRdata, 32'h3);

    // R1: reset mid-run clears outputs and pending flag
    coreEn = 1; coreWe = 1; coreAddr = 8'h72; busEn = 1; busWe = 1; busAddr = 8'h72;
    rstN = 0;
    @(posedge clk); #1;
    chk("R1 collision in reset", {31'b0, collision}, 32'd0);
    chk("R1 vid in reset", vidRdata, '0);
    idle();
    rstN = 1;
    @(posedge clk); #1;

    doneFlag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule